// File: doc/BRIEF.md
# Tile Render Command Stream Generator

This block produces the byte stream of render commands for a rectangle of screen tiles. Up to six surfaces can take part: color read, depth/stencil read, depth/stencil write, color write, multisample color write and multisample depth/stencil write. Each surface has a present flag and a base address. Each read surface also has a full-resolution flag. A single start pulse launches a run over the tile range `min_x..max_x` by `min_y..max_y`. During the run the block emits an optional clear preamble, then one rendering-mode configuration packet, then one packet group per tile.

Inside a tile the content depends on which surfaces are present. Loads come first and are separated when needed. A tile-coordinate packet always follows the loads. When binning is enabled, a semaphore wait comes before the first tile and a branch into that tile's binned list follows in every tile. Stores come last, in a fixed order, with a coordinate packet between each pair of stores.

Bytes leave one at a time on a valid/ready interface. A one-cycle `done` pulse follows the final accepted byte, and `stream_len` then holds the number of bytes emitted. Validating the surfaces, fetching memory and executing the commands are handled elsewhere.

Top module: `tile_cmd_gen`

## Requirements
- R1: Tiles are visited with y in the outer loop and x in the inner loop, each running from its minimum to its maximum inclusive. The first tile is (min_x,min_y) and the last is (max_x,max_y).
- R2: With `use_clear` set, the stream begins with three packets. The first is a clear packet: opcode 114, color0, color1, depth (32 bits each) and stencil (8 bits). The second is a coordinate packet for (0,0). The third is a general store (opcode 28) with zero mode bits and a zero address.
- R3: A configuration packet comes next. It holds opcode 113, then the color-write address (zero when that surface is absent), then frame width, frame height and the 16 color-write mode bits.
- R4: Per tile the color load precedes the depth/stencil load. A general load uses opcode 29, 16 mode bits and the base address. When both loads are general, a coordinate packet and a no-op general store are placed between them. The no-op store has opcode 28, mode bits 0x7000 and address 0.
- R5: A full-resolution load uses opcode 27, and a multisample store uses opcode 26. Their address is base + 16384 × (ceil(width/32) × y + x). This address is ORed with 0x2 (skip depth) for a color surface or 0x4 (skip color) for a depth surface.
- R6: After the loads, every tile emits a coordinate packet: opcode 115, then the x byte, then the y byte.
- R7: With binning enabled, opcode 8 (wait) is emitted in the first tile only. Every tile emits a branch: opcode 17 followed by tile_alloc_base + (y × bin_tiles_x + x) × 32.
- R8: Stores follow the order multisample color, multisample depth, general depth, color. A coordinate packet is placed between each consecutive pair of stores.
- R9: A multisample store that is not the tile's last store ORs 0x1 into its address. A general depth store followed by a color store ORs 0x1000 into its mode bits. The last store of the last tile alone marks end of frame. A color store uses opcode 25 instead of 24 for this. Any other store ORs 0x8 into its address.
- R10: Multi-byte fields are sent least-significant byte first. Packet lengths are: clear 14, configuration 11, general load/store 7, full-resolution load/store and branch 5, coordinate 3, wait and color store 1.
- R11: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_valid` hold. No byte is lost or repeated.
- R12: One cycle after the last byte is accepted, `done` pulses for a single cycle with `out_valid` low. `stream_len` then equals the number of bytes accepted.
- R13: After reset, `out_valid`, `done` and `stream_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (taken when idle) |
| surf_present | input | 6 | Present flags: 0 color rd, 1 depth rd, 2 depth wr, 3 color wr, 4 ms color wr, 5 ms depth wr |
| rd_full | input | 2 | Full-resolution flag: 0 color rd, 1 depth rd |
| surf_addr | input | 192 | Six 32-bit base addresses, surface i at bits 32i+31:32i |
| surf_bits | input | 64 | Four 16-bit mode words for surfaces 0..3 |
| min_x | input | 8 | First tile column |
| max_x | input | 8 | Last tile column |
| min_y | input | 8 | First tile row |
| max_y | input | 8 | Last tile row |
| frame_w | input | 16 | Frame width in pixels |
| frame_h | input | 16 | Frame height in pixels |
| bin_en | input | 1 | Binned lists present |
| bin_tiles_x | input | 8 | Binned tile columns |
| tile_alloc_base | input | 32 | Base of binned per-tile lists |
| use_clear | input | 1 | Emit clear preamble |
| clear_c0 | input | 32 | Clear color word 0 |
| clear_c1 | input | 32 | Clear color word 1 |
| clear_z | input | 32 | Clear depth |
| clear_s | input | 8 | Clear stencil |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes byte |
| out_byte | output | 8 | Stream byte |
| done | output | 1 | Run complete pulse |
| stream_len | output | 32 | Bytes emitted in the run |

## Verification
The assertions assume that every configuration input stays steady from `start` to `done`. They also assume `min_x <= max_x` and `min_y <= max_y`, that at least one write surface is present, and that full-resolution bases are 16-byte aligned so the flag bits land in zero bits. The stimulus table uses only such configurations and aligned base addresses. Inputs change only between runs, and `start` is pulsed only while the block is idle. Back-pressure comes from a periodic ready pattern, which never alters the configuration.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  localparam int NSTEP = 18;
  localparam int TILE_STEP0 = 4;
  localparam int COORD_W = 8;
  localparam int SF_CR = 0, SF_ZR = 1, SF_ZW = 2, SF_CW = 3, SF_MC = 4, SF_MZ = 5;

  typedef enum logic [4:0] {
    ST_CLR, ST_CLR_XY, ST_CLR_ST, ST_CFG,
    ST_LD_C, ST_LD_XY, ST_LD_NOP, ST_LD_Z, ST_XY, ST_WAIT, ST_BR,
    ST_SMC, ST_SMZ_XY, ST_SMZ, ST_SZ_XY, ST_SZ, ST_SC_XY, ST_SC
  } step_e;

  // first enabled step at or after 'from'; NSTEP when none
  function automatic logic [4:0] find_step(input logic [NSTEP-1:0] en, input int from);
    logic [4:0] r;
    r = 5'(NSTEP);
    for (int i = NSTEP - 1; i >= 0; i--)
      if (i >= from && en[i]) r = 5'(i);
    return r;
  endfunction

  function automatic logic [31:0] full_res_addr(input logic [31:0] base, input logic [15:0] w,
                                                input logic [7:0] x, input logic [7:0] y,
                                                input logic [31:0] tile_bytes);
    logic [31:0] stride;
    stride = (32'(w) + 32'd31) >> 5;
    return base + tile_bytes * (stride * 32'(y) + 32'(x));
  endfunction

  function automatic logic [31:0] branch_addr(input logic [31:0] base, input logic [7:0] bx,
                                              input logic [7:0] x, input logic [7:0] y);
    return base + ((32'(y) * 32'(bx) + 32'(x)) << 5);
  endfunction
endpackage

// File: rtl/tcg_walker.sv
module tcg_walker
  import tcg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [5:0]        present,
  input  logic [1:0]        rd_full,
  input  logic              use_clear,
  input  logic              bin_en,
  input  logic [COORD_W-1:0] min_x,
  input  logic [COORD_W-1:0] max_x,
  input  logic [COORD_W-1:0] min_y,
  input  logic [COORD_W-1:0] max_y,
  input  logic              slot_free,
  input  logic              ser_empty,
  output logic              load,
  output logic              launch,
  output step_e             step,
  output logic [COORD_W-1:0] tile_x,
  output logic [COORD_W-1:0] tile_y,
  output logic              last_tile,
  output logic              done
);
  typedef enum logic [1:0] {W_IDLE, W_RUN, W_DRAIN} wst_e;
  wst_e wst;
  logic [NSTEP-1:0] en;
  logic first_tile, both_gen, any_ms;
  logic [4:0] nxt;

  always_comb begin
    first_tile = (tile_x == min_x) && (tile_y == min_y);
    last_tile  = (tile_x == max_x) && (tile_y == max_y);
    both_gen   = present[SF_CR] && present[SF_ZR] && !rd_full[0] && !rd_full[1];
    any_ms     = present[SF_MC] || present[SF_MZ];
    en = '0;
    en[ST_CLR]    = use_clear;
    en[ST_CLR_XY] = use_clear;
    en[ST_CLR_ST] = use_clear;
    en[ST_CFG]    = 1'b1;
    en[ST_LD_C]   = present[SF_CR];
    en[ST_LD_XY]  = both_gen;
    en[ST_LD_NOP] = both_gen;
    en[ST_LD_Z]   = present[SF_ZR];
    en[ST_XY]     = 1'b1;
    en[ST_WAIT]   = bin_en && first_tile;
    en[ST_BR]     = bin_en;
    en[ST_SMC]    = present[SF_MC];
    en[ST_SMZ_XY] = present[SF_MC] && present[SF_MZ];
    en[ST_SMZ]    = present[SF_MZ];
    en[ST_SZ_XY]  = present[SF_ZW] && any_ms;
    en[ST_SZ]     = present[SF_ZW];
    en[ST_SC_XY]  = present[SF_CW] && (any_ms || present[SF_ZW]);
    en[ST_SC]     = present[SF_CW];
  end

  assign load   = (wst == W_RUN) && slot_free;
  assign launch = (wst == W_IDLE) && start;
  assign nxt    = find_step(en, int'(step) + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst <= W_IDLE; step <= ST_CFG; tile_x <= '0; tile_y <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (wst)
        W_IDLE: if (start) begin
          tile_x <= min_x; tile_y <= min_y;
          step   <= step_e'(find_step(en, 0));
          wst    <= W_RUN;
        end
        W_RUN: if (load) begin
          if (nxt != 5'(NSTEP)) step <= step_e'(nxt);
          else if (last_tile) wst <= W_DRAIN;
          else begin
            if (tile_x == max_x) begin
              tile_x <= min_x; tile_y <= tile_y + 1'b1;
            end else tile_x <= tile_x + 1'b1;
            step <= step_e'(find_step(en, TILE_STEP0));
          end
        end
        default: if (ser_empty) begin
          done <= 1'b1; wst <= W_IDLE;
        end
      endcase
    end
  end

  p_step_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wst == W_RUN) |-> en[step]);
  p_tile_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wst == W_RUN) |-> (tile_x >= min_x && tile_x <= max_x && tile_y >= min_y && tile_y <= max_y));
  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/tcg_packet.sv
module tcg_packet
  import tcg_pkg::*;
#(
  parameter int PKT_BYTES  = 16,
  parameter int LENW       = 5,
  parameter int TILE_BYTES = 16384,
  parameter logic [7:0] OP_CLEAR = 8'd114, OP_CFG = 8'd113, OP_COORD = 8'd115,
  parameter logic [7:0] OP_LD_GEN = 8'd29, OP_ST_GEN = 8'd28,
  parameter logic [7:0] OP_LD_FULL = 8'd27, OP_ST_FULL = 8'd26,
  parameter logic [7:0] OP_ST_COLOR = 8'd24, OP_ST_COLOR_EOF = 8'd25,
  parameter logic [7:0] OP_BRANCH = 8'd17, OP_WAIT = 8'd8,
  parameter int GEN_DIS_COLOR_BIT = 12, GEN_DIS_ZS_BIT = 13, GEN_DIS_AUX_BIT = 14,
  parameter int GEN_EOF_BIT = 3,
  parameter int FR_DIS_CLR_BIT = 0, FR_DIS_ZS_BIT = 1, FR_DIS_COLOR_BIT = 2, FR_EOF_BIT = 3
) (
  input  step_e               step,
  input  logic [COORD_W-1:0]  tile_x,
  input  logic [COORD_W-1:0]  tile_y,
  input  logic                last_tile,
  input  logic [5:0]          present,
  input  logic [1:0]          rd_full,
  input  logic [191:0]        surf_addr,
  input  logic [63:0]         surf_bits,
  input  logic [15:0]         frame_w,
  input  logic [15:0]         frame_h,
  input  logic [7:0]          bin_tiles_x,
  input  logic [31:0]         tile_alloc_base,
  input  logic [31:0]         clear_c0,
  input  logic [31:0]         clear_c1,
  input  logic [31:0]         clear_z,
  input  logic [7:0]          clear_s,
  output logic [8*PKT_BYTES-1:0] pkt,
  output logic [LENW-1:0]     pkt_len
);
  localparam logic [15:0] GEN_DIS_COLOR_M = 16'(1) << GEN_DIS_COLOR_BIT;
  localparam logic [15:0] NOP_BITS = GEN_DIS_COLOR_M | (16'(1) << GEN_DIS_ZS_BIT) |
                                     (16'(1) << GEN_DIS_AUX_BIT);
  localparam logic [31:0] GEN_EOF_M    = 32'(1) << GEN_EOF_BIT;
  localparam logic [31:0] FR_DIS_CLR_M = 32'(1) << FR_DIS_CLR_BIT;
  localparam logic [31:0] FR_DIS_ZS_M  = 32'(1) << FR_DIS_ZS_BIT;
  localparam logic [31:0] FR_DIS_COL_M = 32'(1) << FR_DIS_COLOR_BIT;
  localparam logic [31:0] FR_EOF_M     = 32'(1) << FR_EOF_BIT;

  logic [31:0] sa [6];
  logic [15:0] sb [4];
  for (genvar i = 0; i < 6; i++) begin : g_addr
    assign sa[i] = surf_addr[32*i +: 32];
  end
  for (genvar i = 0; i < 4; i++) begin : g_bits
    assign sb[i] = surf_bits[16*i +: 16];
  end

  // trailing flags of a multisample store: clear-suppress or end of frame
  function automatic logic [31:0] store_tail(input logic is_last, input logic lt);
    return is_last ? (lt ? FR_EOF_M : 32'd0) : FR_DIS_CLR_M;
  endfunction

  logic [31:0] fr_base, fr_addr;
  logic mc_last, mz_last;

  always_comb begin
    case (step)
      ST_LD_C: fr_base = sa[SF_CR];
      ST_LD_Z: fr_base = sa[SF_ZR];
      ST_SMC:  fr_base = sa[SF_MC];
      default: fr_base = sa[SF_MZ];
    endcase
    fr_addr = full_res_addr(fr_base, frame_w, tile_x, tile_y, 32'(TILE_BYTES));
    mc_last = !(present[SF_MZ] || present[SF_ZW] || present[SF_CW]);
    mz_last = !(present[SF_ZW] || present[SF_CW]);
  end

  always_comb begin
    pkt = '0;
    pkt_len = '0;
    case (step)
      ST_CLR: begin
        pkt[7:0] = OP_CLEAR; pkt[39:8] = clear_c0; pkt[71:40] = clear_c1;
        pkt[103:72] = clear_z; pkt[111:104] = clear_s; pkt_len = LENW'(14);
      end
      ST_CLR_XY: begin pkt[7:0] = OP_COORD; pkt_len = LENW'(3); end
      ST_CLR_ST: begin pkt[7:0] = OP_ST_GEN; pkt_len = LENW'(7); end
      ST_CFG: begin
        pkt[7:0] = OP_CFG;
        pkt[39:8] = present[SF_CW] ? sa[SF_CW] : 32'd0;
        pkt[55:40] = frame_w; pkt[71:56] = frame_h; pkt[87:72] = sb[SF_CW];
        pkt_len = LENW'(11);
      end
      ST_LD_C, ST_LD_Z: begin
        if (rd_full[step == ST_LD_Z]) begin
          pkt[7:0] = OP_LD_FULL;
          pkt[39:8] = fr_addr | ((step == ST_LD_Z) ? FR_DIS_COL_M : FR_DIS_ZS_M);
          pkt_len = LENW'(5);
        end else begin
          pkt[7:0] = OP_LD_GEN;
          pkt[23:8] = (step == ST_LD_Z) ? sb[SF_ZR] : sb[SF_CR];
          pkt[55:24] = (step == ST_LD_Z) ? sa[SF_ZR] : sa[SF_CR];
          pkt_len = LENW'(7);
        end
      end
      ST_LD_XY, ST_XY, ST_SMZ_XY, ST_SZ_XY, ST_SC_XY: begin
        pkt[7:0] = OP_COORD; pkt[15:8] = tile_x; pkt[23:16] = tile_y; pkt_len = LENW'(3);
      end
      ST_LD_NOP: begin pkt[7:0] = OP_ST_GEN; pkt[23:8] = NOP_BITS; pkt_len = LENW'(7); end
      ST_WAIT: begin pkt[7:0] = OP_WAIT; pkt_len = LENW'(1); end
      ST_BR: begin
        pkt[7:0] = OP_BRANCH;
        pkt[39:8] = branch_addr(tile_alloc_base, bin_tiles_x, tile_x, tile_y);
        pkt_len = LENW'(5);
      end
      ST_SMC: begin
        pkt[7:0] = OP_ST_FULL;
        pkt[39:8] = fr_addr | FR_DIS_ZS_M | store_tail(mc_last, last_tile);
        pkt_len = LENW'(5);
      end
      ST_SMZ: begin
        pkt[7:0] = OP_ST_FULL;
        pkt[39:8] = fr_addr | FR_DIS_COL_M | store_tail(mz_last, last_tile);
        pkt_len = LENW'(5);
      end
      ST_SZ: begin
        pkt[7:0] = OP_ST_GEN;
        pkt[23:8] = sb[SF_ZW] | (present[SF_CW] ? GEN_DIS_COLOR_M : 16'd0);
        pkt[55:24] = sa[SF_ZW] | ((last_tile && !present[SF_CW]) ? GEN_EOF_M : 32'd0);
        pkt_len = LENW'(7);
      end
      ST_SC: begin
        pkt[7:0] = last_tile ? OP_ST_COLOR_EOF : OP_ST_COLOR; pkt_len = LENW'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tcg_shifter.sv
module tcg_shifter #(
  parameter int PKT_BYTES = 16,
  parameter int LENW      = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [8*PKT_BYTES-1:0] pkt,
  input  logic [LENW-1:0]        pkt_len,
  input  logic                   out_ready,
  output logic                   out_valid,
  output logic [7:0]             out_byte,
  output logic                   slot_free,
  output logic                   empty,
  output logic                   accept
);
  logic [8*PKT_BYTES-1:0] shreg;
  logic [LENW-1:0] cnt;

  assign out_valid = (cnt != '0);
  assign out_byte  = shreg[7:0];
  assign accept    = out_valid && out_ready;
  assign empty     = (cnt == '0);
  assign slot_free = empty || (cnt == LENW'(1) && out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0; cnt <= '0;
    end else if (load) begin
      shreg <= pkt; cnt <= pkt_len;
    end else if (accept) begin
      shreg <= shreg >> 8; cnt <= cnt - 1'b1;
    end
  end

  p_hold_under_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
  p_load_only_when_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (empty || (cnt == LENW'(1) && out_ready)));
endmodule

// File: rtl/tile_cmd_gen.sv
module tile_cmd_gen
  import tcg_pkg::*;
#(
  parameter int PKT_BYTES  = 16,
  parameter int TILE_BYTES = 16384
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   surf_present,
  input  logic [1:0]   rd_full,
  input  logic [191:0] surf_addr,
  input  logic [63:0]  surf_bits,
  input  logic [7:0]   min_x,
  input  logic [7:0]   max_x,
  input  logic [7:0]   min_y,
  input  logic [7:0]   max_y,
  input  logic [15:0]  frame_w,
  input  logic [15:0]  frame_h,
  input  logic         bin_en,
  input  logic [7:0]   bin_tiles_x,
  input  logic [31:0]  tile_alloc_base,
  input  logic         use_clear,
  input  logic [31:0]  clear_c0,
  input  logic [31:0]  clear_c1,
  input  logic [31:0]  clear_z,
  input  logic [7:0]   clear_s,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [7:0]   out_byte,
  output logic         done,
  output logic [31:0]  stream_len
);
  localparam int LENW = $clog2(PKT_BYTES + 1);

  step_e step;
  logic [COORD_W-1:0] tile_x, tile_y;
  logic last_tile, load, launch, slot_free, empty, accept;
  logic [8*PKT_BYTES-1:0] pkt;
  logic [LENW-1:0] pkt_len;

  tcg_walker u_walk (
    .clk, .rst_n, .start, .present(surf_present), .rd_full, .use_clear, .bin_en,
    .min_x, .max_x, .min_y, .max_y, .slot_free, .ser_empty(empty),
    .load, .launch, .step, .tile_x, .tile_y, .last_tile, .done
  );

  tcg_packet #(.PKT_BYTES(PKT_BYTES), .LENW(LENW), .TILE_BYTES(TILE_BYTES)) u_pkt (
    .step, .tile_x, .tile_y, .last_tile, .present(surf_present), .rd_full,
    .surf_addr, .surf_bits, .frame_w, .frame_h, .bin_tiles_x, .tile_alloc_base,
    .clear_c0, .clear_c1, .clear_z, .clear_s, .pkt, .pkt_len
  );

  tcg_shifter #(.PKT_BYTES(PKT_BYTES), .LENW(LENW)) u_shift (
    .clk, .rst_n, .load, .pkt, .pkt_len, .out_ready,
    .out_valid, .out_byte, .slot_free, .empty, .accept
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stream_len <= '0;
    else if (launch) stream_len <= '0;
    else if (accept) stream_len <= stream_len + 32'd1;
  end

  p_done_after_drain_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
  p_len_frozen_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(stream_len));
endmodule

// File: tb/tile_cmd_gen_bench.sv
module tile_cmd_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CASE_LIMIT = 6000;

  typedef struct packed {
    logic [5:0]  pres;
    logic [1:0]  full;
    logic        clr;
    logic        bin;
    logic [7:0]  mnx, mxx, mny, mxy;
    logic [15:0] w;
  } cfg_t;

  // presence bits: 0 color rd, 1 depth rd, 2 depth wr, 3 color wr, 4 ms color, 5 ms depth
  localparam cfg_t TBL [10] = '{
    '{6'b001000, 2'b00, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 16'd64},
    '{6'b001100, 2'b00, 1'b1, 1'b1, 8'd1, 8'd2, 8'd0, 8'd1, 16'd128},
    '{6'b001011, 2'b00, 1'b0, 1'b0, 8'd0, 8'd2, 8'd0, 8'd0, 16'd96},
    '{6'b110011, 2'b11, 1'b0, 1'b0, 8'd0, 8'd1, 8'd0, 8'd1, 16'd64},
    '{6'b111111, 2'b00, 1'b1, 1'b1, 8'd2, 8'd3, 8'd1, 8'd2, 16'd160},
    '{6'b000100, 2'b00, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd2, 16'd32},
    '{6'b010000, 2'b00, 1'b0, 1'b0, 8'd0, 8'd2, 8'd0, 8'd1, 16'd100},
    '{6'b001111, 2'b01, 1'b0, 1'b1, 8'd0, 8'd1, 8'd0, 8'd0, 16'd64},
    '{6'b001100, 2'b00, 1'b0, 1'b1, 8'd1, 8'd3, 8'd2, 8'd3, 16'd200},
    '{6'b101000, 2'b00, 1'b1, 1'b0, 8'd0, 8'd1, 8'd0, 8'd1, 16'd64}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3"; 1: return "R2"; 2: return "R4"; 3: return "R5";
      4: return "R8"; 5: return "R9"; 6: return "R1"; 7: return "R6";
      8: return "R7"; default: return "R10";
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [5:0] surf_present = '0;
  logic [1:0] rd_full = '0;
  logic [191:0] surf_addr;
  logic [63:0] surf_bits;
  logic [7:0] min_x = '0, max_x = '0, min_y = '0, max_y = '0, bin_tiles_x = 8'd8;
  logic [15:0] frame_w = 16'd64, frame_h = 16'd48;
  logic bin_en = 1'b0, use_clear = 1'b0;
  logic [31:0] tile_alloc_base = 32'h2000_0000;
  logic [31:0] clear_c0 = 32'hA1B2_C3D4, clear_c1 = 32'h0F1E_2D3C, clear_z = 32'h00FF_EE01;
  logic [7:0] clear_s = 8'h5A;
  logic out_valid, done;
  logic [7:0] out_byte;
  logic [31:0] stream_len;

  int n_checks = 0, n_fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  tile_cmd_gen u_tile_cmd_gen (
    .clk, .rst_n, .start, .surf_present, .rd_full, .surf_addr, .surf_bits,
    .min_x, .max_x, .min_y, .max_y, .frame_w, .frame_h, .bin_en, .bin_tiles_x,
    .tile_alloc_base, .use_clear, .clear_c0, .clear_c1, .clear_z, .clear_s,
    .out_valid, .out_ready, .out_byte, .done, .stream_len
  );

  function automatic logic [31:0] base_of(input int i);
    return 32'h1000_0000 + 32'(i) * 32'h0010_0000;
  endfunction
  function automatic logic [15:0] bits_of(input int i);
    return 16'h0A51 + 16'(i * 3);
  endfunction
  function automatic logic [31:0] fr(input int i, input int w, input int x, input int y);
    int stride;
    stride = (w + 31) / 32;
    return base_of(i) + 32'(16384 * (stride * y + x));
  endfunction

  task automatic put8(input logic [7:0] v); exp_q.push_back(v); endtask
  task automatic put16(input logic [15:0] v); put8(v[7:0]); put8(v[15:8]); endtask
  task automatic put32(input logic [31:0] v); put16(v[15:0]); put16(v[31:16]); endtask
  task automatic put_xy(input int x, input int y); put8(8'd115); put8(8'(x)); put8(8'(y)); endtask

  task automatic build(input cfg_t c);
    exp_q.delete();
    if (c.clr) begin
      put8(8'd114); put32(clear_c0); put32(clear_c1); put32(clear_z); put8(clear_s);
      put_xy(0, 0);
      put8(8'd28); put16(16'h0000); put32(32'h0);
    end
    put8(8'd113); put32(c.pres[3] ? base_of(3) : 32'h0);
    put16(c.w); put16(frame_h); put16(bits_of(3));
    for (int y = int'(c.mny); y <= int'(c.mxy); y++) begin
      for (int x = int'(c.mnx); x <= int'(c.mxx); x++) begin
        bit first, last;
        int nst;
        first = (x == int'(c.mnx)) && (y == int'(c.mny));
        last  = (x == int'(c.mxx)) && (y == int'(c.mxy));
        if (c.pres[0]) begin
          if (c.full[0]) begin put8(8'd27); put32(fr(0, int'(c.w), x, y) | 32'h2); end
          else begin put8(8'd29); put16(bits_of(0)); put32(base_of(0)); end
        end
        if (c.pres[1]) begin
          if (c.full[1]) begin put8(8'd27); put32(fr(1, int'(c.w), x, y) | 32'h4); end
          else begin
            if (c.pres[0] && !c.full[0]) begin
              put_xy(x, y); put8(8'd28); put16(16'h7000); put32(32'h0);
            end
            put8(8'd29); put16(bits_of(1)); put32(base_of(1));
          end
        end
        put_xy(x, y);
        if (c.bin && first) put8(8'd8);
        if (c.bin) begin
          put8(8'd17);
          put32(tile_alloc_base + 32'((y * int'(bin_tiles_x) + x) * 32));
        end
        nst = 0;
        if (c.pres[4]) begin
          bit ls;
          ls = !(c.pres[5] || c.pres[2] || c.pres[3]);
          put8(8'd26);
          put32(fr(4, int'(c.w), x, y) | 32'h2 | (ls ? (last ? 32'h8 : 32'h0) : 32'h1));
          nst++;
        end
        if (c.pres[5]) begin
          bit ls;
          ls = !(c.pres[2] || c.pres[3]);
          if (nst > 0) put_xy(x, y);
          put8(8'd26);
          put32(fr(5, int'(c.w), x, y) | 32'h4 | (ls ? (last ? 32'h8 : 32'h0) : 32'h1));
          nst++;
        end
        if (c.pres[2]) begin
          if (nst > 0) put_xy(x, y);
          put8(8'd28); put16(bits_of(2) | (c.pres[3] ? 16'h1000 : 16'h0));
          put32(base_of(2) | ((last && !c.pres[3]) ? 32'h8 : 32'h0));
          nst++;
        end
        if (c.pres[3]) begin
          if (nst > 0) put_xy(x, y);
          put8(last ? 8'd25 : 8'd24);
        end
      end
    end
  endtask

  task automatic run_case(input cfg_t c, input bit stall, input string tag);
    bit finished;
    int cyc;
    surf_present = c.pres; rd_full = c.full; use_clear = c.clr; bin_en = c.bin;
    min_x = c.mnx; max_x = c.mxx; min_y = c.mny; max_y = c.mxy; frame_w = c.w;
    build(c);
    got_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    finished = 1'b0;
    cyc = 0;
    while (!finished && cyc < CASE_LIMIT) begin
      out_ready = stall ? ((cyc % 5) != 1 && (cyc % 7) != 3) : 1'b1;
      if (out_valid && out_ready) got_q.push_back(out_byte);
      if (done) finished = 1'b1;
      else begin @(negedge clk); cyc++; end
    end
    out_ready = 1'b1;
    n_checks++;
    if (!finished) begin
      n_fails++;
      $display("FAIL %s watchdog: no done after %0d cycles (expected done)", tag, cyc);
    end
    n_checks++;
    begin
      int bad;
      bad = -1;
      for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
        if (bad < 0 && got_q[k] !== exp_q[k]) bad = k;
      if (bad >= 0) begin
        n_fails++;
        $display("FAIL %s byte %0d: actual %02h expected %02h", tag, bad, got_q[bad], exp_q[bad]);
      end else if (got_q.size() != exp_q.size()) begin
        n_fails++;
        $display("FAIL %s stream size: actual %0d expected %0d", tag, got_q.size(), exp_q.size());
      end
    end
    n_checks++;
    if (stream_len !== 32'(exp_q.size())) begin
      n_fails++;
      $display("FAIL R12 (%s) length: actual %0d expected %0d", tag, stream_len, exp_q.size());
    end
    @(negedge clk);
    n_checks++;
    if (done !== 1'b0) begin
      n_fails++;
      $display("FAIL R12 (%s) done width: actual %b expected 0", tag, done);
    end
  endtask

  initial begin
    for (int i = 0; i < 6; i++) surf_addr[32*i +: 32] = base_of(i);
    for (int i = 0; i < 4; i++) surf_bits[16*i +: 16] = bits_of(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || done !== 1'b0 || stream_len !== 32'd0) begin
      n_fails++;
      $display("FAIL R13 reset: actual v=%b d=%b len=%0d expected 0/0/0", out_valid, done, stream_len);
    end
    for (int i = 0; i < 10; i++) run_case(TBL[i], 1'b0, tag_of(i));
    run_case(TBL[4], 1'b1, "R11");
    run_case(TBL[3], 1'b1, "R11");
    run_case(TBL[8], 1'b1, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule